// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This control block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It compares register numbers and picks the operand source for the instruction in execute. Each execute operand can come from the register file or from a newer result. That result is either the value held in the execute/memory pipeline register or the value leaving the memory stage. A source register that matches in both places takes the newer value.

It also finds the one case that forwarding cannot cover. A load sits in execute, and the instruction behind it in decode reads the loaded register. The unit then holds the program counter and the fetch/decode register for one cycle and turns the slot entering execute into a no-op. A cycle later the loaded value is forwarded from the memory stage output. Branches are predicted not taken. When a branch in execute resolves taken, the unit cancels the instruction in decode and the instruction being fetched, and fetch restarts at the target. The datapath applies the outputs at the next rising edge.

The register file is assumed to write in the first half of a cycle and read in the second half. A value being written back therefore reaches decode directly and needs no forwarding to that stage. Register zero is hard-wired and never acts as a producer. All results are combinational functions of the current pipeline-register fields. The clock and reset pins serve only the embedded property checks.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the execute/memory stage writes a nonzero register equal to an execute source, that operand's select is 2'b10. Each operand is judged independently.
- R2: When only the memory/write-back stage writes a nonzero register equal to an execute source, that operand's select is 2'b01. With no match the select is 2'b00, meaning the register file.
- R3: When both later stages write the register an execute source names, the execute/memory value wins and the select is 2'b10.
- R4: Register zero as a destination never causes forwarding and never causes a stall.
- R5: A load in execute (ex_wen=1, ex_is_load=1) whose destination equals a source that decode reads causes a stall: pc_hold=1, ifid_hold=1, ex_bubble=1. A non-load producer in execute never stalls.
- R6: A decode source whose use flag is 0 never causes a stall.
- R7: ex_redirect=1 gives ifid_flush=1 and ex_bubble=1 with pc_hold=0 and ifid_hold=0, even when a load-use match is present.
- R8: Destinations in the memory or write-back stages that match a decode source cause no stall and no flush.
- R9: A stage whose write enable is 0 is never used as a forwarding source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| dec_rs | input | RW | First source register of the instruction in decode |
| dec_rt | input | RW | Second source register of the instruction in decode |
| dec_uses_rs | input | 1 | Decode instruction reads dec_rs |
| dec_uses_rt | input | 1 | Decode instruction reads dec_rt |
| ex_rs | input | RW | First source register of the instruction in execute |
| ex_rt | input | RW | Second source register of the instruction in execute |
| ex_rd | input | RW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | RW | Destination register held in the execute/memory register |
| mem_wen | input | 1 | That instruction writes a register |
| wb_rd | input | RW | Destination register held in the memory/write-back register |
| wb_wen | input | 1 | That instruction writes a register |
| ex_redirect | input | 1 | Branch in execute resolved taken (prediction wrong) |
| fwd_a | output | 2 | First operand source: 00 register file, 01 write-back value, 10 execute/memory value |
| fwd_b | output | 2 | Second operand source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this edge |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this edge |
| ex_bubble | output | 1 | Clear control bits entering execute (no-op) |
| ifid_flush | output | 1 | Replace the fetch/decode register contents with a no-op |

## Verification
Every output is due in the same cycle as the pipeline fields that produce it, and the datapath consumes it at the following rising edge. The bench changes inputs on the falling edge and samples 2 ns later, well before the next rising edge, so no check races the edge. The stall has a follow-on effect. One cycle after a stall the pipeline has moved on, and the loaded value must be forwarded from the write-back side. The bench checks this by presenting the advanced stage contents in the next cycle and sampling the select then.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  input  logic          dec_uses_rs,
  input  logic          dec_uses_rt,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          ex_redirect,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ex_bubble,
  output logic          ifid_flush
);

  localparam logic [RW-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live, load_live;
  logic load_use, stall;

  assign mem_live  = mem_wen && (mem_rd != ZERO_REG);
  assign wb_live   = wb_wen  && (wb_rd  != ZERO_REG);
  assign load_live = ex_wen && ex_is_load && (ex_rd != ZERO_REG);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic m_ok, input logic [RW-1:0] m_rd,
                                      input logic w_ok, input logic [RW-1:0] w_rd);
    if (m_ok && m_rd == src)      return SEL_MEM;
    else if (w_ok && w_rd == src) return SEL_WB;
    else                          return SEL_RF;
  endfunction

  assign fwd_a = pick(ex_rs, mem_live, mem_rd, wb_live, wb_rd);
  assign fwd_b = pick(ex_rt, mem_live, mem_rd, wb_live, wb_rd);

  assign load_use = load_live &&
                    ((dec_uses_rs && dec_rs == ex_rd) || (dec_uses_rt && dec_rt == ex_rd));
  assign stall    = load_use && !ex_redirect;

  assign pc_hold    = stall;
  assign ifid_hold  = stall;
  assign ex_bubble  = stall || ex_redirect;
  assign ifid_flush = ex_redirect;

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_a) && $onehot0(fwd_b)); // R2
  AST_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && mem_rd != ZERO_REG && mem_rd == ex_rs) |-> fwd_a == SEL_MEM); // R3
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == SEL_WB) |-> (wb_rd != ZERO_REG && wb_wen)); // R4
  AST_STALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (ex_is_load && ex_wen && ex_rd != ZERO_REG)); // R5
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (ifid_hold && ex_bubble && !ifid_flush)); // R5
  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> (ifid_flush && ex_bubble && !pc_hold && !ifid_hold)); // R7
  AST_NO_WEN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == SEL_MEM) |-> mem_wen); // R9

endmodule

// File: tb/hazard_fwd_unit_test.sv
module hazard_fwd_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] dec_rs, dec_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic dec_uses_rs, dec_uses_rt, ex_wen, ex_is_load, mem_wen, wb_wen, ex_redirect;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ex_bubble, ifid_flush;

  hazard_fwd_unit #(.RW(5)) uut (
    .clk(clk), .rst_n(rst_n),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_uses_rs(dec_uses_rs), .dec_uses_rt(dec_uses_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .ex_redirect(ex_redirect),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ex_bubble(ex_bubble), .ifid_flush(ifid_flush)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] drs, drt;
    logic [1:0] duse;
    logic [4:0] xrs, xrt, xrd;
    logic xw, xl;
    logic [4:0] mrd;
    logic mw;
    logic [4:0] wrd;
    logic ww, red;
    logic [1:0] efa, efb;
    logic es, ef;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    {4'd1, 5'd0,5'd0,2'b00, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd3,1'b1, 5'd0,1'b0, 1'b0, 2'b10,2'b00,1'b0,1'b0},  // R1 operand a
    {4'd1, 5'd0,5'd0,2'b00, 5'd7,5'd9,5'd0,1'b0,1'b0, 5'd9,1'b1, 5'd0,1'b0, 1'b0, 2'b00,2'b10,1'b0,1'b0},  // R1 operand b
    {4'd2, 5'd0,5'd0,2'b00, 5'd5,5'd6,5'd0,1'b0,1'b0, 5'd0,1'b0, 5'd5,1'b1, 1'b0, 2'b01,2'b00,1'b0,1'b0},  // R2 operand a
    {4'd2, 5'd0,5'd0,2'b00, 5'd1,5'd2,5'd0,1'b0,1'b0, 5'd0,1'b0, 5'd2,1'b1, 1'b0, 2'b00,2'b01,1'b0,1'b0},  // R2 operand b
    {4'd3, 5'd0,5'd0,2'b00, 5'd8,5'd8,5'd0,1'b0,1'b0, 5'd8,1'b1, 5'd8,1'b1, 1'b0, 2'b10,2'b10,1'b0,1'b0},  // R3 both match
    {4'd3, 5'd0,5'd0,2'b00, 5'd10,5'd11,5'd0,1'b0,1'b0, 5'd11,1'b1, 5'd10,1'b1, 1'b0, 2'b01,2'b10,1'b0,1'b0}, // R3 split
    {4'd4, 5'd0,5'd0,2'b00, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b1, 5'd0,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0},  // R4 r0 forward
    {4'd9, 5'd0,5'd0,2'b00, 5'd12,5'd13,5'd0,1'b0,1'b0, 5'd12,1'b0, 5'd13,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0}, // R9 wen low
    {4'd5, 5'd4,5'd1,2'b11, 5'd0,5'd0,5'd4,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b1,1'b0},  // R5 rs
    {4'd5, 5'd2,5'd6,2'b11, 5'd0,5'd0,5'd6,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b1,1'b0},  // R5 rt
    {4'd5, 5'd4,5'd1,2'b11, 5'd0,5'd0,5'd4,1'b1,1'b0, 5'd0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0},  // R5 non-load
    {4'd6, 5'd1,5'd6,2'b10, 5'd0,5'd0,5'd6,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0},  // R6 rt unused
    {4'd4, 5'd0,5'd0,2'b11, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0},  // R4 r0 load
    {4'd8, 5'd9,5'd9,2'b11, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd9,1'b1, 5'd9,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0},  // R8 later stages
    {4'd7, 5'd0,5'd0,2'b00, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0, 5'd0,1'b0, 1'b1, 2'b00,2'b00,1'b0,1'b1},  // R7 plain
    {4'd7, 5'd4,5'd1,2'b11, 5'd0,5'd0,5'd4,1'b1,1'b1, 5'd0,1'b0, 5'd0,1'b0, 1'b1, 2'b00,2'b00,1'b0,1'b1}   // R7 over stall
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [7:0] outs();
    return {fwd_a, fwd_b, pc_hold, ifid_hold, ex_bubble, ifid_flush};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_rs = v.drs; dec_rt = v.drt; {dec_uses_rs, dec_uses_rt} = v.duse;
    ex_rs = v.xrs; ex_rt = v.xrt; ex_rd = v.xrd; ex_wen = v.xw; ex_is_load = v.xl;
    mem_rd = v.mrd; mem_wen = v.mw; wb_rd = v.wrd; wb_wen = v.ww; ex_redirect = v.red;
  endtask

  function automatic logic [7:0] expect_of(input vec_t v);
    return {v.efa, v.efb, v.es, v.es, v.es | v.ef, v.ef};
  endfunction

  initial begin
    vec_t idle;
    idle = '0;
    drive(idle);
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R9 reset/idle outputs", outs(), 8'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #2;
      check($sformatf("R%0d row %0d", VECS[i].req, i), outs(), expect_of(VECS[i]));
    end

    // R5 sequence: stall, bubble cycle, then forwarding from write-back side
    @(negedge clk);
    drive(idle);
    dec_rs = 5'd14; dec_uses_rs = 1'b1; ex_rd = 5'd14; ex_wen = 1'b1; ex_is_load = 1'b1;
    #2; check("R5 seq stall", outs(), 8'b0000_1110);
    @(negedge clk);
    drive(idle);
    dec_rs = 5'd14; dec_uses_rs = 1'b1; mem_rd = 5'd14; mem_wen = 1'b1;
    #2; check("R8 seq bubble cycle", outs(), 8'b0);
    @(negedge clk);
    drive(idle);
    ex_rs = 5'd14; wb_rd = 5'd14; wb_wen = 1'b1;
    #2; check("R2 seq load data via wb", outs(), 8'b0100_0000);

    // R6 rs unused while rt not matching
    @(negedge clk);
    drive(idle);
    dec_rs = 5'd20; dec_rt = 5'd21; dec_uses_rt = 1'b1; ex_rd = 5'd20; ex_wen = 1'b1; ex_is_load = 1'b1;
    #2; check("R6 rs unused", outs(), 8'b0);

    // R1 both operands from execute/memory
    @(negedge clk);
    drive(idle);
    ex_rs = 5'd31; ex_rt = 5'd31; mem_rd = 5'd31; mem_wen = 1'b1;
    #2; check("R1 both operands", outs(), 8'b1010_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule